// File: doc/BRIEF.md
# Trusted-Module Command Buffer Control Registers

This block is the register front end of a trusted-module interface that works through a shared command/response buffer. Software reaches it with byte-addressed reads and writes of one to four bytes. Address bits [15:12] carry the requesting locality, and bits [11:0] select a register. The block records whether a locality holds access to the module. It tracks the ready/idle state that software asks for. It turns a correctly gated start or cancel write into a one-cycle pulse to the backend command engine. It also presents fixed identification registers and buffer-location registers.

The backend reports the end of a command with a completion pulse and an error flag. Completion clears the in-flight flag. A nonzero error sets a fatal status bit that stays set until reset. The command buffer memory and the backend engine sit outside this block.

Top module: `crbif_top`

## Requirements
- R1: After reset, the register at offset 0x000 reads 0x80 with bit 0 set when `establishedIn` is 0. This word holds bit 7 register-valid, bits [4:2] active locality (0), and bit 1 locality-assigned. Offset 0x00C (bit 0 granted, bit 1 seized) reads 0. Offset 0x044 (bit 1 idle, bit 0 fatal) reads 0x2. Offset 0x04C (bit 0 in-flight) reads 0.
- R2: Offset 0x030 reads 0x00025811 and offset 0x034 reads VENDOR_ID. The fields of 0x030 are: type [3:0]=1, version [7:4]=1, locality-0-only bit 8=0, idle-fast bit 9=0, transfer-size [12:11]=3, FIFO bit 13=0, buffer-mode bit 14=1, selector [18:17]=1, revision [31:24]=0. Offsets 0x058 and 0x064 read SPAN-DATA_OFS. Offsets 0x05C and 0x068 read BASE_ADDR+DATA_OFS. Writes to all of these are ignored.
- R3: An access is valid when its size is 1 to 4 and (addr[1:0] + size) ≤ 4. A valid read returns the aligned word shifted right by 8·addr[1:0], with no masking. An invalid read returns 0. Registers decode on addr[11:0] for every locality. A write acts only when it is valid and addr[1:0] is 0. Its value is wrData masked to the size in bytes.
- R4: At offset 0x008, writing value 1 sets granted and locality-assigned and clears seized. Value 2 clears granted and locality-assigned. Any other value, including 8, has no effect.
- R5: At offset 0x040, writing value 1 clears the idle bit and value 2 sets it. Any other value, including 3, has no effect.
- R6: A write of value 1 to offset 0x04C is accepted only when all of the following hold: the in-flight bit is clear, locality-assigned is set, and addr[15:12] equals the active locality (0). While locality-assigned is clear, the active locality counts as 0xFF. An accepted write sets the in-flight bit and raises `startPulse` for exactly one cycle, in the cycle after the write edge.
- R7: A write of value 1 to offset 0x048 while the in-flight bit is set raises `cancelPulse` for exactly one cycle, in the cycle after the write edge. Every other cancel write is ignored. Offset 0x048 reads 0.
- R8: A cycle with `doneIn` high clears the in-flight bit. If `doneErr` is also high, the fatal bit is set, even when nothing was in flight. The fatal bit stays set until reset.
- R9: Bit 0 of offset 0x000 always reads as the inverse of `establishedIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address; [15:12] locality, [11:0] register |
| size | input | 3 | Access size in bytes (1..4 valid) |
| wrData | input | 32 | Write data, low bytes significant |
| rdData | output | 32 | Read data, combinational, 0 when rdEn is low |
| establishedIn | input | 1 | Backend established flag |
| doneIn | input | 1 | Backend completion pulse |
| doneErr | input | 1 | Completion carries an error |
| startPulse | output | 1 | One-cycle command start request |
| cancelPulse | output | 1 | One-cycle command cancel request |

## Verification
The bench goes after the start gate from every side. It issues a start without a grant, a start from locality 1, a second start while one is in flight, and a start whose value has extra bits. A design with a loose gate would pulse the backend twice or on behalf of the wrong locality. Other directed cases hit multi-bit control values such as 3 and 8, which a bit-testing decoder would wrongly act on. They also cover reads that straddle a word boundary, which must return 0 rather than wrapped bytes, and an error completion with nothing in flight, which must still latch the fatal bit. A seeded random mix of these operations then runs against a bench-side register model.

// File: rtl/crbif_pkg.sv
package crbif_pkg;

  // register offsets within one locality window
  localparam logic [11:0] OFS_LOC_STATE = 12'h000;
  localparam logic [11:0] OFS_LOC_CTRL  = 12'h008;
  localparam logic [11:0] OFS_LOC_STS   = 12'h00C;
  localparam logic [11:0] OFS_ID_LO     = 12'h030;
  localparam logic [11:0] OFS_ID_HI     = 12'h034;
  localparam logic [11:0] OFS_CTRL_REQ  = 12'h040;
  localparam logic [11:0] OFS_CTRL_STS  = 12'h044;
  localparam logic [11:0] OFS_CANCEL    = 12'h048;
  localparam logic [11:0] OFS_START     = 12'h04C;
  localparam logic [11:0] OFS_CMD_SIZE  = 12'h058;
  localparam logic [11:0] OFS_CMD_ADDR  = 12'h05C;
  localparam logic [11:0] OFS_RSP_SIZE  = 12'h064;
  localparam logic [11:0] OFS_RSP_ADDR  = 12'h068;

  // command codes (exact match required)
  localparam logic [31:0] CODE_GRANT_REQ  = 32'd1;
  localparam logic [31:0] CODE_GRANT_DROP = 32'd2;
  localparam logic [31:0] CODE_READY      = 32'd1;
  localparam logic [31:0] CODE_IDLE       = 32'd2;
  localparam logic [31:0] CODE_INVOKE     = 32'd1;

  localparam logic [7:0] NO_LOCALITY = 8'hFF;

  // control -> datapath strobes
  typedef struct packed {
    logic grantReq;
    logic grantDrop;
    logic goReady;
    logic goIdle;
    logic startGo;
    logic cancelGo;
  } ctrlStrobes_t;

  // datapath -> control state
  typedef struct packed {
    logic       startFlag;
    logic       locAssigned;
    logic [2:0] activeLoc;
  } dpStatus_t;

  function automatic logic [31:0] idWord();
    logic [31:0] w;
    w        = '0;
    w[3:0]   = 4'd1;  // interface type: buffer mode active
    w[7:4]   = 4'd1;  // interface version
    w[8]     = 1'b0;  // locality 0 only
    w[9]     = 1'b0;  // fast idle
    w[12:11] = 2'b11; // 64-byte transfer size
    w[13]    = 1'b0;  // FIFO unsupported
    w[14]    = 1'b1;  // buffer mode supported
    w[18:17] = 2'b01; // selector
    w[31:24] = 8'h00; // revision
    return w;
  endfunction

endpackage

// File: rtl/crbif_ctrl.sv
module crbif_ctrl
  import crbif_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic [31:0]       wrData,
  input  dpStatus_t         status,
  output logic              accessOk,
  output ctrlStrobes_t      strb
);
  localparam int LOC_W = ADDR_W - 12;

  logic [3:0]       endByte;
  logic [31:0]      byteMask;
  logic [31:0]      value;
  logic [11:0]      ofs;
  logic [LOC_W-1:0] reqLoc;
  logic [7:0]       activeEff;
  logic             cmdHit;
  logic             locMatch;

  assign endByte  = {2'b00, addr[1:0]} + {1'b0, size};
  assign accessOk = (size >= 3'd1) && (size <= 3'd4) && (endByte <= 4'd4);

  always_comb begin
    case (size)
      3'd1:    byteMask = 32'h0000_00FF;
      3'd2:    byteMask = 32'h0000_FFFF;
      3'd3:    byteMask = 32'h00FF_FFFF;
      default: byteMask = 32'hFFFF_FFFF;
    endcase
  end

  assign value     = wrData & byteMask;
  assign ofs       = addr[11:0];
  assign reqLoc    = addr[ADDR_W-1:12];
  assign activeEff = status.locAssigned ? {5'b0, status.activeLoc} : NO_LOCALITY;
  assign locMatch  = ({{(8-LOC_W){1'b0}}, reqLoc} == activeEff);
  assign cmdHit    = wrEn && accessOk && (addr[1:0] == 2'b00);

  always_comb begin
    strb = '0;
    if (cmdHit) begin
      unique case (ofs)
        OFS_LOC_CTRL: begin
          strb.grantReq  = (value == CODE_GRANT_REQ);
          strb.grantDrop = (value == CODE_GRANT_DROP);
        end
        OFS_CTRL_REQ: begin
          strb.goReady = (value == CODE_READY);
          strb.goIdle  = (value == CODE_IDLE);
        end
        OFS_START:  strb.startGo  = (value == CODE_INVOKE) && !status.startFlag && locMatch;
        OFS_CANCEL: strb.cancelGo = (value == CODE_INVOKE) && status.startFlag;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/crbif_regs.sv
module crbif_regs
  import crbif_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'hFED4_0000,
  parameter int          SPAN      = 4096,
  parameter int          DATA_OFS  = 128,
  parameter logic [15:0] VENDOR_ID = 16'h1D1A
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strb,
  input  logic         doneIn,
  input  logic         doneErr,
  input  logic         establishedIn,
  input  logic         rdEn,
  input  logic         accessOk,
  input  logic [11:0]  addr,
  output logic [31:0]  rdData,
  output logic         startPulse,
  output logic         cancelPulse,
  output logic         fatalFlag,
  output dpStatus_t    status
);
  localparam logic [31:0] BUF_SIZE = 32'(SPAN - DATA_OFS);
  localparam logic [31:0] BUF_ADDR = BASE_ADDR + 32'(DATA_OFS);

  logic       startFlag, locAssigned, granted, seized, idleFlag, regValid;
  logic [2:0] activeLoc;
  logic [31:0] word;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startFlag   <= 1'b0;
      locAssigned <= 1'b0;
      granted     <= 1'b0;
      seized      <= 1'b0;
      idleFlag    <= 1'b1;
      fatalFlag   <= 1'b0;
      regValid    <= 1'b1;
      activeLoc   <= 3'd0;
      startPulse  <= 1'b0;
      cancelPulse <= 1'b0;
    end else begin
      startPulse  <= strb.startGo;
      cancelPulse <= strb.cancelGo;
      if (strb.grantReq) begin
        granted     <= 1'b1;
        seized      <= 1'b0;
        locAssigned <= 1'b1;
      end else if (strb.grantDrop) begin
        granted     <= 1'b0;
        locAssigned <= 1'b0;
      end
      if (strb.goReady)     idleFlag <= 1'b0;
      else if (strb.goIdle) idleFlag <= 1'b1;
      if (strb.startGo)     startFlag <= 1'b1;
      else if (doneIn)      startFlag <= 1'b0;
      if (doneIn && doneErr) fatalFlag <= 1'b1;
    end
  end

  assign status = '{startFlag: startFlag, locAssigned: locAssigned, activeLoc: activeLoc};

  always_comb begin
    unique case ({addr[11:2], 2'b00})
      OFS_LOC_STATE: word = {24'b0, regValid, 2'b00, activeLoc, locAssigned, !establishedIn};
      OFS_LOC_STS:   word = {30'b0, seized, granted};
      OFS_ID_LO:     word = idWord();
      OFS_ID_HI:     word = {16'b0, VENDOR_ID};
      OFS_CTRL_STS:  word = {30'b0, idleFlag, fatalFlag};
      OFS_START:     word = {31'b0, startFlag};
      OFS_CMD_SIZE,
      OFS_RSP_SIZE:  word = BUF_SIZE;
      OFS_CMD_ADDR,
      OFS_RSP_ADDR:  word = BUF_ADDR;
      default:       word = 32'b0;
    endcase
  end

  assign rdData = (rdEn && accessOk) ? (word >> {addr[1:0], 3'b000}) : 32'b0;

endmodule

// File: rtl/crbif_top.sv
module crbif_top
  import crbif_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [31:0] BASE_ADDR = 32'hFED4_0000,
  parameter int          SPAN      = 4096,
  parameter int          DATA_OFS  = 128,
  parameter logic [15:0] VENDOR_ID = 16'h1D1A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic              establishedIn,
  input  logic              doneIn,
  input  logic              doneErr,
  output logic              startPulse,
  output logic              cancelPulse
);
  ctrlStrobes_t strb;
  dpStatus_t    status;
  logic         accessOk;
  logic         fatalFlag;
  logic         startFlag;
  logic         locAssigned;

  assign startFlag   = status.startFlag;
  assign locAssigned = status.locAssigned;

  crbif_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .addr(addr), .size(size), .wrData(wrData),
    .status(status), .accessOk(accessOk), .strb(strb)
  );

  crbif_regs #(
    .BASE_ADDR(BASE_ADDR), .SPAN(SPAN), .DATA_OFS(DATA_OFS), .VENDOR_ID(VENDOR_ID)
  ) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .doneIn(doneIn), .doneErr(doneErr),
    .establishedIn(establishedIn), .rdEn(rdEn), .accessOk(accessOk),
    .addr(addr[11:0]), .rdData(rdData), .startPulse(startPulse),
    .cancelPulse(cancelPulse), .fatalFlag(fatalFlag), .status(status)
  );

endmodule

// File: rtl/crbif_checker.sv
module crbif_checker (
  input logic clk,
  input logic rstN,
  input logic startPulse,
  input logic cancelPulse,
  input logic doneIn,
  input logic startFlag,
  input logic locAssigned,
  input logic fatalFlag
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse); // R6
  AST_START_MARKS_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> (startFlag && !$past(startFlag))); // R6
  AST_START_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(locAssigned)); // R6
  AST_CANCEL_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    cancelPulse |-> $past(startFlag)); // R7
  AST_CANCEL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    cancelPulse |=> !cancelPulse); // R7
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (doneIn && startFlag) |=> !startFlag); // R8
  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    fatalFlag |=> fatalFlag); // R8
endmodule

bind crbif_top crbif_checker u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .cancelPulse(cancelPulse),
  .doneIn(doneIn), .startFlag(startFlag), .locAssigned(locAssigned),
  .fatalFlag(fatalFlag)
);

// File: tb/crbif_top_bench.sv
module crbif_top_bench;
  localparam logic [31:0] ID_LO    = 32'h0002_5811;
  localparam logic [15:0] VID      = 16'h1D1A;
  localparam logic [31:0] BUF_SIZE = 32'h0000_0F80;
  localparam logic [31:0] BUF_ADDR = 32'hFED4_0080;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] addr = '0;
  logic [2:0]  size = 3'd4;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic establishedIn = 1'b0, doneIn = 1'b0, doneErr = 1'b0;
  logic startPulse, cancelPulse;

  int nChk = 0, nBad = 0;
  bit finished = 0;

  // bench model
  bit mStart, mAssigned, mGranted, mSeized, mIdle, mFatal;

  crbif_top u_crbif_top (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .size(size),
    .wrData(wrData), .rdData(rdData), .establishedIn(establishedIn),
    .doneIn(doneIn), .doneErr(doneErr), .startPulse(startPulse),
    .cancelPulse(cancelPulse)
  );

  always #10 clk = ~clk;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modelWord(logic [11:0] ofs);
    case ({ofs[11:2], 2'b00})
      12'h000: return {24'b0, 1'b1, 2'b00, 3'b000, mAssigned, !establishedIn};
      12'h00C: return {30'b0, mSeized, mGranted};
      12'h030: return ID_LO;
      12'h034: return {16'b0, VID};
      12'h044: return {30'b0, mIdle, mFatal};
      12'h04C: return {31'b0, mStart};
      12'h058, 12'h064: return BUF_SIZE;
      12'h05C, 12'h068: return BUF_ADDR;
      default: return 32'b0;
    endcase
  endfunction

  function automatic bit validAcc(logic [1:0] bofs, int sz);
    return (sz >= 1) && (sz <= 4) && (int'(bofs) + sz <= 4);
  endfunction

  function automatic logic [31:0] modelRead(logic [11:0] ofs, int sz);
    if (!validAcc(ofs[1:0], sz)) return 32'b0;
    return modelWord(ofs) >> (8 * int'(ofs[1:0]));
  endfunction

  task automatic resetModel();
    mStart = 0; mAssigned = 0; mGranted = 0; mSeized = 0; mIdle = 1; mFatal = 0;
  endtask

  task automatic doRead(int loc, logic [11:0] ofs, int sz, string tag);
    logic [31:0] exp;
    @(negedge clk);
    addr = {loc[3:0], ofs}; size = 3'(sz); rdEn = 1'b1;
    @(negedge clk);
    exp = modelRead(ofs, sz);
    check(rdData === exp, tag, rdData, exp);
    check(startPulse === 1'b0 && cancelPulse === 1'b0, "R6 R7 pulse width",
          {30'b0, cancelPulse, startPulse}, 32'b0);
    rdEn = 1'b0;
  endtask

  task automatic doWrite(int loc, logic [11:0] ofs, int sz, logic [31:0] data);
    bit hit, expS, expC;
    logic [31:0] v, m;
    hit = validAcc(ofs[1:0], sz) && ofs[1:0] == 2'b00;
    m = (sz >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * sz)) - 1);
    v = data & m;
    expS = hit && ofs == 12'h04C && v == 1 && !mStart && mAssigned && loc == 0;
    expC = hit && ofs == 12'h048 && v == 1 && mStart;
    @(negedge clk);
    addr = {loc[3:0], ofs}; size = 3'(sz); wrData = data; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    check(startPulse === expS, "R6 start gate", {31'b0, startPulse}, {31'b0, expS});
    check(cancelPulse === expC, "R7 cancel gate", {31'b0, cancelPulse}, {31'b0, expC});
    if (hit && ofs == 12'h008) begin
      if (v == 1) begin mGranted = 1; mSeized = 0; mAssigned = 1; end
      else if (v == 2) begin mGranted = 0; mAssigned = 0; end
    end
    if (hit && ofs == 12'h040) begin
      if (v == 1) mIdle = 0;
      else if (v == 2) mIdle = 1;
    end
    if (expS) mStart = 1;
  endtask

  task automatic doDone(bit err);
    @(negedge clk);
    doneIn = 1'b1; doneErr = err;
    @(negedge clk);
    doneIn = 1'b0; doneErr = 1'b0;
    mStart = 0;
    if (err) mFatal = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [11:0] wrOfs [7];
    logic [11:0] rdOfs [10];
    logic [31:0] vals [6];
    void'($urandom(32'h0BAD_C0DE));
    resetModel();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    doRead(0, 12'h000, 4, "R1 loc state reset");
    doRead(0, 12'h00C, 4, "R1 loc status reset");
    doRead(0, 12'h044, 4, "R1 ctrl status reset");
    doRead(0, 12'h04C, 4, "R1 start reset");
    // R9 established flag inversion
    establishedIn = 1'b1;
    doRead(0, 12'h000, 4, "R9 established inverse");
    establishedIn = 1'b0;
    // R2 fixed registers, writes ignored
    doRead(0, 12'h030, 4, "R2 id lo");
    doRead(0, 12'h034, 4, "R2 id hi");
    doWrite(0, 12'h058, 4, 32'h1234_5678);
    doWrite(0, 12'h030, 4, 32'hFFFF_FFFF);
    doRead(0, 12'h058, 4, "R2 cmd size");
    doRead(0, 12'h068, 4, "R2 rsp addr");
    doRead(1, 12'h030, 4, "R2 id after write");
    // R3 shift and invalid accesses
    doRead(0, 12'h05E, 2, "R3 shifted halfword");
    doRead(0, 12'h033, 1, "R3 top byte");
    doRead(0, 12'h032, 4, "R3 straddle reads zero");
    doRead(0, 12'h030, 0, "R3 size zero reads zero");
    doRead(0, 12'h030, 5, "R3 size five reads zero");
    // R6 start without grant rejected
    doWrite(0, 12'h04C, 4, 1);
    doRead(0, 12'h04C, 4, "R6 no grant no start");
    // R4 grant via multi-bit and reset-establishment codes ignored
    doWrite(0, 12'h008, 4, 8);
    doWrite(0, 12'h008, 4, 3);
    doRead(0, 12'h00C, 4, "R4 codes 8 and 3 ignored");
    doWrite(0, 12'h009, 1, 1);
    doRead(0, 12'h00C, 4, "R3 R4 offset write ignored");
    doWrite(0, 12'h008, 1, 32'hFFFF_FF01);
    doRead(0, 12'h00C, 4, "R4 grant byte write");
    doRead(0, 12'h000, 4, "R4 assigned set");
    // R5 control requests
    doWrite(0, 12'h040, 4, 3);
    doRead(0, 12'h044, 4, "R5 value 3 ignored");
    doWrite(0, 12'h040, 4, 1);
    doRead(0, 12'h044, 4, "R5 ready clears idle");
    doWrite(0, 12'h040, 4, 2);
    doRead(0, 12'h044, 4, "R5 idle sets idle");
    // R6 gate corners
    doWrite(1, 12'h04C, 4, 1);
    doWrite(0, 12'h04C, 4, 3);
    doRead(0, 12'h04C, 4, "R6 wrong loc or value");
    // R7 cancel with nothing in flight
    doWrite(0, 12'h048, 4, 1);
    doWrite(0, 12'h04C, 4, 1);
    doRead(0, 12'h04C, 4, "R6 accepted start");
    doWrite(0, 12'h04C, 4, 1);
    doWrite(0, 12'h048, 4, 2);
    doWrite(0, 12'h048, 4, 1);
    doRead(0, 12'h048, 4, "R7 cancel reads zero");
    // R8 completion
    doDone(1'b0);
    doRead(0, 12'h04C, 4, "R8 done clears start");
    doRead(0, 12'h044, 4, "R8 no error no fatal");
    doDone(1'b1);
    doRead(0, 12'h044, 4, "R8 error idle completion sets fatal");
    // relinquish
    doWrite(2, 12'h008, 4, 2);
    doRead(0, 12'h00C, 4, "R4 relinquish");
    doWrite(0, 12'h04C, 4, 1);
    doRead(0, 12'h000, 4, "R4 R6 state after drop");

    // reset again before random phase so fatal is clear
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    resetModel();
    doRead(0, 12'h044, 4, "R1 fatal cleared by reset");

    wrOfs = '{12'h008, 12'h040, 12'h04C, 12'h048, 12'h030, 12'h058, 12'h000};
    rdOfs = '{12'h000, 12'h00C, 12'h030, 12'h034, 12'h044, 12'h04C,
              12'h058, 12'h05C, 12'h064, 12'h068};
    vals  = '{32'd1, 32'd2, 32'd8, 32'd3, 32'd0, 32'd1};
    for (int i = 0; i < 1500; i++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 4) begin
        int sz, loc;
        logic [11:0] o;
        logic [31:0] d;
        o = wrOfs[$urandom % 7];
        if ($urandom % 6 == 0) o[1:0] = 2'($urandom);
        sz = ($urandom % 3 == 0) ? int'($urandom % 6) : 4;
        loc = ($urandom % 4 == 0) ? 1 : 0;
        d = ($urandom % 5 == 0) ? $urandom : vals[$urandom % 6];
        doWrite(loc, o, sz, d);
      end else if (op < 8) begin
        logic [11:0] o;
        o = rdOfs[$urandom % 10];
        o[1:0] = 2'($urandom);
        doRead(int'($urandom % 3), o, int'($urandom % 6), "R3 random read");
      end else if (op == 8) begin
        doDone(($urandom % 16) == 0);
      end else begin
        establishedIn = 1'($urandom);
        doRead(0, 12'h000, 4, "R9 random established");
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule